// File: doc/BRIEF.md
# Calibration Register Refresh Controller

This block keeps the active calibration state of a sensor signal conditioner in step with the nonvolatile coefficient array. The active state is one configuration word and four 12-bit DAC coefficients: offset, offset temperature coefficient, span, and span temperature coefficient. A reload reads the five stored words one per cycle into a shadow buffer. After the last word arrives, all five active registers update in a single cycle, so downstream logic never sees a mix of old and new coefficients.

A reload is triggered in two ways:
- a rising edge on chip-select, unless the latched update-hold bit is set;
- a free-running refresh timer, which runs only while write-enable is high.

Both triggers are suppressed while a serial session is active. A trigger that arrives while the nonvolatile array reports busy is held pending and is served once busy clears.

Serial direct writes follow a separate path. They land in a staging bank and reach the active registers only when a load strobe commits them. The configuration word is decoded into gain, sign, coarse-offset and resistor-select fields.

Top module: `nvr_refresh_ctrl`

## Requirements
- R1: While reset is held, every DAC output and every decoded configuration field is zero.
- R2: A reload copies bits 11:0 of stored word 0 to the configuration register, and of words 1, 2, 3 and 4 to the offset, offset-TC, span and span-TC outputs respectively. Bits 15:12 of each word are ignored.
- R3: Configuration decode:
  - bit 0 is the offset sign and bit 1 the offset-TC sign;
  - gain is {bit2, bit3, bit4}, with bit 2 as the MSB;
  - bits 5 and 6 are ignored;
  - bit 7 is the resistor select;
  - bit 8 is the coarse-offset sign;
  - coarse magnitude is {bit9, bit10, bit11}, with bit 9 as the MSB.
- R4: A chip-select rising edge starts a reload when the hold bit is 0. When the hold bit is 1 the edge has no effect.
- R5: While write-enable is high, a reload starts every REFRESH_CYCLES cycles. While it is low, no periodic reload occurs.
- R6: While the session input is high, no reload starts or completes. A trigger seen during a session is discarded.
- R7: A trigger raised while the nonvolatile array is busy is deferred. Exactly that reload is performed after busy falls.
- R8: A direct write, selected by wr_sel 0..4 in the same order as R2, changes no output until a load strobe. Selects 5..7 are ignored.
- R9: A load strobe commits every staged register and leaves the others unchanged. When it falls in the same cycle as a reload commit, the staged value wins for staged registers and the reloaded value applies to the rest.
- R10: Active registers change only in the cycle after a reload commit or a load strobe.
- R11: A reload reads word addresses 0 through 4 in ascending order, one per cycle. Read data is expected one cycle after the read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip-select level |
| we_i | input | 1 | Write-enable level; gates the periodic refresh |
| hold_upd_i | input | 1 | Latched update-hold bit from the serial preamble |
| session_i | input | 1 | Serial session active (past the unlock preamble) |
| nv_busy_i | input | 1 | Nonvolatile array busy with a write or erase |
| nv_rd_en_o | output | 1 | Word read enable toward the array |
| nv_rd_addr_o | output | 3 | Word address |
| nv_rd_data_i | input | 16 | Word read data, one cycle after enable |
| wr_en_i | input | 1 | Direct-write strobe |
| wr_sel_i | input | 3 | Direct-write target register |
| wr_data_i | input | 12 | Direct-write value |
| load_i | input | 1 | Commit strobe for staged values |
| offset_dac_o | output | 12 | Offset DAC coefficient |
| offtc_dac_o | output | 12 | Offset-TC DAC coefficient |
| fso_dac_o | output | 12 | Span DAC coefficient |
| fsotc_dac_o | output | 12 | Span-TC DAC coefficient |
| off_sign_o | output | 1 | Offset sign |
| offtc_sign_o | output | 1 | Offset-TC sign |
| pga_gain_o | output | 3 | Amplifier gain code |
| res_sel_o | output | 1 | Internal resistor select |
| crs_sign_o | output | 1 | Coarse offset sign |
| crs_mag_o | output | 3 | Coarse offset magnitude |

## Verification
The reload commit and the load strobe can land on the same clock edge, and both then write the active registers. The bench stages values for a subset of the registers and raises a chip-select edge. It counts the cycles of the read sequence and pulses the load strobe exactly in the cycle in which the shadow buffer is committed. It then compares each output with its own origin: registers that had a staged value must show that value, and the others must show the freshly read stored word.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

    localparam int DATA_W   = 12;
    localparam int NV_W     = 16;
    localparam int NUM_REGS = 5;
    localparam int WIDX_W   = 3;

    localparam int REG_CFG   = 0;
    localparam int REG_OFF   = 1;
    localparam int REG_OFFTC = 2;
    localparam int REG_FSO   = 3;
    localparam int REG_FSOTC = 4;

    typedef logic [DATA_W-1:0] cal_word_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0] cal_bank_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_DRAIN,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic       off_sign;
        logic       offtc_sign;
        logic [2:0] pga_gain;
        logic       res_sel;
        logic       crs_sign;
        logic [2:0] crs_mag;
    } cfg_fields_t;

    function automatic cfg_fields_t decode_cfg(cal_word_t w);
        cfg_fields_t f;
        f.off_sign   = w[0];
        f.offtc_sign = w[1];
        f.pga_gain   = {w[2], w[3], w[4]};
        f.res_sel    = w[7];
        f.crs_sign   = w[8];
        f.crs_mag    = {w[9], w[10], w[11]};
        return f;
    endfunction

endpackage

// File: rtl/nvr_trigger.sv
module nvr_trigger
    import nvr_pkg::*;
#(
    parameter int REFRESH_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_i,
    input  logic hold_upd_i,
    input  logic we_i,
    input  logic session_i,
    output logic req_o
);
    localparam int CNT_W = $clog2(REFRESH_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFRESH_CYCLES - 1);

    logic             cs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             cs_rise;

    assign cs_rise = cs_i & ~cs_q;
    assign tick    = we_i & (cnt_q == LAST);
    assign req_o   = ((cs_rise & ~hold_upd_i) | tick) & ~session_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            cs_q <= cs_i;
            if (!we_i || cnt_q == LAST) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R5
    cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> cnt_q == '0);

endmodule

// File: rtl/nvr_reload_seq.sv
module nvr_reload_seq
    import nvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              nv_busy_i,
    input  logic              session_i,
    output logic              nv_rd_en_o,
    output logic [WIDX_W-1:0] nv_rd_addr_o,
    input  logic [NV_W-1:0]   nv_rd_data_i,
    output logic              commit_o,
    output cal_bank_t         shadow_o
);
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(NUM_REGS - 1);

    seq_state_e        state_q;
    logic [WIDX_W-1:0] idx_q;
    logic [WIDX_W-1:0] cap_idx_q;
    logic              cap_vld_q;
    logic              pend_q;
    logic              start;
    cal_bank_t         shadow_q;

    assign start        = (pend_q | req_i) & (state_q == SEQ_IDLE) & ~nv_busy_i & ~session_i;
    assign nv_rd_en_o   = (state_q == SEQ_READ) & ~session_i;
    assign nv_rd_addr_o = idx_q;
    assign commit_o     = (state_q == SEQ_DONE) & ~session_i;
    assign shadow_o     = shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            idx_q     <= '0;
            cap_idx_q <= '0;
            cap_vld_q <= 1'b0;
            pend_q    <= 1'b0;
            shadow_q  <= '0;
        end else begin
            pend_q    <= (pend_q | req_i) & ~start & ~session_i;
            cap_vld_q <= nv_rd_en_o;
            cap_idx_q <= idx_q;
            if (cap_vld_q)
                shadow_q[cap_idx_q] <= nv_rd_data_i[DATA_W-1:0];
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_READ;
                        idx_q   <= '0;
                    end
                end
                SEQ_READ: begin
                    if (session_i) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) state_q <= SEQ_DRAIN;
                    end
                end
                SEQ_DRAIN: state_q <= session_i ? SEQ_IDLE : SEQ_DONE;
                SEQ_DONE:  state_q <= SEQ_IDLE;
                default:   state_q <= SEQ_IDLE;
            endcase
        end
    end

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_READ && $past(state_q) == SEQ_IDLE) |-> !$past(nv_busy_i));

    // R11
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        nv_rd_en_o |-> nv_rd_addr_o <= LAST_IDX);

    // R11
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (nv_rd_en_o && $past(nv_rd_en_o)) |-> nv_rd_addr_o == $past(nv_rd_addr_o) + 1'b1);

    // R6
    session_commit_chk: assert property (@(posedge clk) disable iff (rst)
        session_i |=> !commit_o);

endmodule

// File: rtl/nvr_stage.sv
module nvr_stage
    import nvr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [WIDX_W-1:0]   wr_sel_i,
    input  cal_word_t           wr_data_i,
    input  logic                load_i,
    output cal_bank_t           stg_o,
    output logic [NUM_REGS-1:0] vld_o
);
    cal_bank_t           stg_q;
    logic [NUM_REGS-1:0] vld_q;

    assign stg_o = stg_q;
    assign vld_o = vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
            vld_q <= '0;
        end else begin
            if (load_i) vld_q <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_en_i && wr_sel_i == WIDX_W'(i)) begin
                    stg_q[i] <= wr_data_i;
                    vld_q[i] <= 1'b1;
                end
            end
        end
    end

    // R8
    stage_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !wr_en_i) |=> vld_q == '0);

endmodule

// File: rtl/nvr_refresh_ctrl.sv
module nvr_refresh_ctrl
    import nvr_pkg::*;
#(
    parameter int REFRESH_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic              hold_upd_i,
    input  logic              session_i,
    input  logic              nv_busy_i,
    output logic              nv_rd_en_o,
    output logic [2:0]        nv_rd_addr_o,
    input  logic [15:0]       nv_rd_data_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [11:0]       wr_data_i,
    input  logic              load_i,
    output logic [11:0]       offset_dac_o,
    output logic [11:0]       offtc_dac_o,
    output logic [11:0]       fso_dac_o,
    output logic [11:0]       fsotc_dac_o,
    output logic              off_sign_o,
    output logic              offtc_sign_o,
    output logic [2:0]        pga_gain_o,
    output logic              res_sel_o,
    output logic              crs_sign_o,
    output logic [2:0]        crs_mag_o
);
    logic                req;
    logic                commit;
    cal_bank_t           shadow;
    cal_bank_t           stg;
    logic [NUM_REGS-1:0] stg_vld;
    cal_bank_t           act_q;
    cfg_fields_t         cfg;

    nvr_trigger #(.REFRESH_CYCLES(REFRESH_CYCLES)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .cs_i       (cs_i),
        .hold_upd_i (hold_upd_i),
        .we_i       (we_i),
        .session_i  (session_i),
        .req_o      (req)
    );

    nvr_reload_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .nv_busy_i    (nv_busy_i),
        .session_i    (session_i),
        .nv_rd_en_o   (nv_rd_en_o),
        .nv_rd_addr_o (nv_rd_addr_o),
        .nv_rd_data_i (nv_rd_data_i),
        .commit_o     (commit),
        .shadow_o     (shadow)
    );

    nvr_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .load_i    (load_i),
        .stg_o     (stg),
        .vld_o     (stg_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (load_i && stg_vld[i]) act_q[i] <= stg[i];
                else if (commit)          act_q[i] <= shadow[i];
            end
        end
    end

    assign cfg          = decode_cfg(act_q[REG_CFG]);
    assign offset_dac_o = act_q[REG_OFF];
    assign offtc_dac_o  = act_q[REG_OFFTC];
    assign fso_dac_o    = act_q[REG_FSO];
    assign fsotc_dac_o  = act_q[REG_FSOTC];
    assign off_sign_o   = cfg.off_sign;
    assign offtc_sign_o = cfg.offtc_sign;
    assign pga_gain_o   = cfg.pga_gain;
    assign res_sel_o    = cfg.res_sel;
    assign crs_sign_o   = cfg.crs_sign;
    assign crs_mag_o    = cfg.crs_mag;

    // R10
    reg_change_chk: assert property (@(posedge clk) disable iff (rst)
        act_q != $past(act_q) |-> ($past(commit) || $past(load_i)));

    // R8
    no_load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!commit && !load_i) |=> $stable(act_q));

endmodule

// File: tb/tb_nvr_refresh_ctrl.sv
`timescale 1ns/1ps
module tb_nvr_refresh_ctrl;

    localparam int PER = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b1, we = 1'b0, hold = 1'b0, sess = 1'b0, busy = 1'b0;
    logic        rd_en;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic        load = 1'b0;
    logic [11:0] o_off, o_offtc, o_fso, o_fsotc;
    logic        o_os, o_ots, o_rs, o_cs;
    logic [2:0]  o_gain, o_cmag;

    logic [15:0] mem [8];
    logic [11:0] exp_r [5];
    int total = 0, fails = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    nvr_refresh_ctrl #(.REFRESH_CYCLES(PER)) dut (
        .clk(clk), .rst(rst), .cs_i(cs), .we_i(we), .hold_upd_i(hold),
        .session_i(sess), .nv_busy_i(busy), .nv_rd_en_o(rd_en),
        .nv_rd_addr_o(rd_addr), .nv_rd_data_i(rd_data), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .load_i(load),
        .offset_dac_o(o_off), .offtc_dac_o(o_offtc), .fso_dac_o(o_fso),
        .fsotc_dac_o(o_fsotc), .off_sign_o(o_os), .offtc_sign_o(o_ots),
        .pga_gain_o(o_gain), .res_sel_o(o_rs), .crs_sign_o(o_cs), .crs_mag_o(o_cmag)
    );

    function automatic logic [57:0] pack_exp();
        logic [11:0] c;
        c = exp_r[0];
        return {exp_r[1], exp_r[2], exp_r[3], exp_r[4],
                c[0], c[1], c[2], c[3], c[4], c[7], c[8], c[9], c[10], c[11]};
    endfunction

    function automatic logic [57:0] pack_act();
        return {o_off, o_offtc, o_fso, o_fsotc, o_os, o_ots, o_gain, o_rs, o_cs, o_cmag};
    endfunction

    task automatic check(input string req);
        total++;
        if (pack_act() !== pack_exp()) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, pack_act(), pack_exp());
        end
    endtask

    task automatic fill(input int p);
        for (int k = 0; k < 8; k++)
            mem[k] = 16'((p * 16'h3B7) + (k * 16'h1C9)) ^ 16'(k << 13) ^ 16'hA000;
    endtask

    task automatic take_mem();
        for (int k = 0; k < 5; k++) exp_r[k] = mem[k][11:0];
    endtask

    task automatic cs_pulse();
        @(negedge clk) cs = 1'b0;
        @(negedge clk) cs = 1'b1;
    endtask

    task automatic direct_write(input logic [2:0] s, input logic [11:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_sel = s; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk) load = 1'b1;
        @(negedge clk) load = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) mem[k] = '0;
        for (int k = 0; k < 5; k++) exp_r[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset");
        rst = 1'b0;
        repeat (15) @(negedge clk);
        check("R1 post-reset zero load");

        // R2 R3 sweep of stored patterns through chip-select reloads
        for (int p = 0; p < 24; p++) begin
            fill(p);
            cs_pulse();
            repeat (12) @(negedge clk);
            take_mem();
            check("R2 R3 R11 reload pattern");
        end
        // R3 walking single bits in config word
        for (int b = 0; b < 12; b++) begin
            mem[0] = 16'hF000 | 16'(1 << b);
            cs_pulse();
            repeat (12) @(negedge clk);
            take_mem();
            check("R3 config bit decode");
        end

        // R4 hold bit set: edge ignored
        hold = 1'b1;
        fill(50);
        cs_pulse();
        repeat (15) @(negedge clk);
        check("R4 hold suppresses reload");
        hold = 1'b0;
        cs_pulse();
        repeat (12) @(negedge clk);
        take_mem();
        check("R4 hold clear reload");

        // R5 periodic refresh
        fill(51);
        @(negedge clk) we = 1'b1;
        repeat (PER + 15) @(negedge clk);
        take_mem();
        check("R5 periodic refresh with we high");
        @(negedge clk) we = 1'b0;
        repeat (12) @(negedge clk);
        fill(52);
        repeat (3 * PER) @(negedge clk);
        check("R5 no refresh with we low");

        // R6 session blocks edge and periodic triggers
        sess = 1'b1;
        cs_pulse();
        @(negedge clk) we = 1'b1;
        repeat (3 * PER) @(negedge clk);
        check("R6 session blocks reload");
        @(negedge clk) we = 1'b0;
        sess = 1'b0;
        repeat (15) @(negedge clk);
        check("R6 discarded trigger not replayed");

        // R7 busy defers
        busy = 1'b1;
        cs_pulse();
        repeat (30) @(negedge clk);
        check("R7 deferred while busy");
        busy = 1'b0;
        repeat (12) @(negedge clk);
        take_mem();
        check("R7 reload after busy clears");

        // R8 R9 direct writes per register
        for (int s = 0; s < 5; s++) begin
            direct_write(3'(s), 12'(12'h5A3 + s * 12'h111));
            repeat (3) @(negedge clk);
            check("R8 staged write no effect");
            pulse_load();
            @(negedge clk);
            exp_r[s] = 12'(12'h5A3 + s * 12'h111);
            check("R9 load commits staged");
        end
        for (int s = 5; s < 8; s++) begin
            direct_write(3'(s), 12'hFFF);
            pulse_load();
            @(negedge clk);
            check("R8 out-of-range select ignored");
        end
        pulse_load();
        @(negedge clk);
        check("R9 empty load no change");

        // R9 collision: load in the commit cycle of a reload
        fill(60);
        direct_write(3'd1, 12'h0C3);
        direct_write(3'd4, 12'h3C0);
        @(negedge clk) cs = 1'b0;
        @(negedge clk) cs = 1'b1;
        @(posedge clk);
        repeat (6) @(posedge clk);
        @(negedge clk) load = 1'b1;
        @(negedge clk) load = 1'b0;
        take_mem();
        exp_r[1] = 12'h0C3;
        exp_r[4] = 12'h3C0;
        check("R9 collision staged wins");
        repeat (5) @(negedge clk);
        check("R10 stable after collision");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule